// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer and Commit Engine

This block sits behind the serial command decoder of a small byte-wide EEPROM. When the decoder reports a write command together with its 9-bit start address, the block opens a 16-byte page latch. The upper five address bits give the page. The lower four bits give the starting column. Each data byte the decoder delivers goes into the current column, and the column then advances. When the column passes the last location of the page it returns to the first one, so a byte sent later replaces the one held there.

The decoder reports the chip-select rise as a strobe and gives the number of bits received since the last whole byte. On that strobe the block decides whether to commit. It commits only when the rise lands on a byte boundary, at least one data byte has arrived, no abort is present, and the protection logic grants the write.

A commit starts a self-timed programming cycle of `CYCLE_CLKS` clocks. During this cycle the block copies only the columns that were actually received into the 512x8 array, one column per clock, and holds `busy` high. It ignores every other request until the cycle ends. A one-clock `done` pulse follows, so that the status logic can clear its in-progress and write-enable bits. The array also has a read port for the rest of the device.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are 0, `rd_data` is 0xFF, and every array location reads 0xFF.
- R2: A data byte is latched at the column given by start address bits [3:0] and lands, after commit, at array address {start bits [8:4], column}. Each later byte uses the next column.
- R3: The column advances from 15 to 0 inside the same page. A byte latched at a column already filled replaces the earlier byte. No location outside the page is written.
- R4: Columns of the page that received no byte keep their previous array contents.
- R5: A commit happens only when `cs_rise` arrives with `cs_bits` equal to 0 and at least one data byte received since the start. Any other `cs_rise` ends the command without writing.
- R6: If `wr_allowed` is 0 when `cs_rise` arrives, nothing is written and `busy` stays 0.
- R7: `abort` ends the command being collected. Bytes and `cs_rise` that follow it, before a new start, write nothing.
- R8: After a committing `cs_rise` at a clock edge, `busy` is 1 for exactly `CYCLE_CLKS` cycles starting right after that edge. `done` is 1 for one cycle, the first cycle in which `busy` is 0 again.
- R9: While `busy` is 1, the following have no effect on the array or the cycle: `wr_start`, `wr_byte_valid`, `cs_rise`, `abort` and `rd_en`. `rd_data` holds its value during this time.
- R10: When idle, `rd_en` with `rd_addr` makes `rd_data` show that array location one cycle later.
- R11: `mem_we` is 1 only while `busy` is 1. It pulses once per received column, carrying that column's address and byte on `mem_addr`/`mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Write command and address received (one-cycle strobe) |
| wr_start_addr | input | 9 | Start address of the write |
| wr_byte_valid | input | 1 | A complete data byte is available |
| wr_byte | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select went inactive (one-cycle strobe) |
| cs_bits | input | 3 | Bits received past the last whole byte when chip select rose |
| wr_allowed | input | 1 | Permission from the protection logic, sampled on `cs_rise` |
| abort | input | 1 | Cancel the command being collected |
| rd_en | input | 1 | Array read request |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-cycle pulse after the programming cycle ends |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
On every cycle, the assertions check the following. `busy` rises only after a `cs_rise` on a byte boundary. `busy` never outlasts `CYCLE_CLKS`. `done` only follows the fall of `busy`. Array writes happen only inside the cycle. The page latch and `rd_data` stay frozen while busy. Only the bench's scenarios can show what lands where: the column wrap and the overwrite, which columns are left untouched, and the cancellation by a bad bit count, a refused permission or an abort. The bench's reference model also compares `busy`, `done`, the write port and `rd_data` on every clock.

// File: rtl/epw_pkg.sv
package epw_pkg;
  localparam int EPW_ADDR_W     = 9;
  localparam int EPW_DATA_W     = 8;
  localparam int EPW_PAGE_BYTES = 16;
  localparam int EPW_COL_W      = $clog2(EPW_PAGE_BYTES);
  localparam int EPW_PAGE_W     = EPW_ADDR_W - EPW_COL_W;
  localparam int EPW_BIT_W      = $clog2(EPW_DATA_W);
  localparam int EPW_DEPTH      = 1 << EPW_ADDR_W;
  localparam logic [EPW_DATA_W-1:0] EPW_ERASED = '1;

  typedef logic [EPW_ADDR_W-1:0] addr_t;
  typedef logic [EPW_COL_W-1:0]  col_t;
  typedef logic [EPW_PAGE_W-1:0] page_t;

  typedef enum logic [1:0] {PH_IDLE, PH_COPY, PH_HOLD} phase_t;

  function automatic page_t page_of(addr_t a);
    return a[EPW_ADDR_W-1:EPW_COL_W];
  endfunction

  function automatic col_t col_of(addr_t a);
    return a[EPW_COL_W-1:0];
  endfunction

  function automatic addr_t join_addr(page_t p, col_t c);
    return {p, c};
  endfunction

  // column advance wraps inside the page by the width of col_t
  function automatic col_t col_step(col_t c);
    return c + col_t'(1);
  endfunction

  function automatic logic on_boundary(logic [EPW_BIT_W-1:0] bits);
    return bits == '0;
  endfunction
endpackage

// File: rtl/epw_page_latch.sv
module epw_page_latch
  import epw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy,
  input  logic                  abort,
  input  logic                  start,
  input  addr_t                 start_addr,
  input  logic                  byte_valid,
  input  logic [EPW_DATA_W-1:0] byte_data,
  input  logic                  cs_rise,
  input  col_t                  rd_col,
  output logic                  collecting,
  output logic                  have_byte,
  output page_t                 page_base,
  output logic [EPW_DATA_W-1:0] rd_byte,
  output logic                  rd_vld
);
  logic                      coll_q, have_q;
  page_t                     base_q;
  col_t                      col_q;
  logic [EPW_PAGE_BYTES-1:0] mask_q;
  logic [EPW_DATA_W-1:0]     slot_q [EPW_PAGE_BYTES];

  // internal events brought out for the checks
  logic close_cmd, take_start, take_byte;
  assign close_cmd  = (abort || cs_rise) && !busy;
  assign take_start = start && !busy && !close_cmd;
  assign take_byte  = byte_valid && coll_q && !busy && !close_cmd && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_q <= 1'b0;
      have_q <= 1'b0;
      base_q <= '0;
      col_q  <= '0;
      mask_q <= '0;
    end else if (close_cmd) begin
      coll_q <= 1'b0;
    end else if (take_start) begin
      coll_q <= 1'b1;
      have_q <= 1'b0;
      base_q <= page_of(start_addr);
      col_q  <= col_of(start_addr);
      mask_q <= '0;
    end else if (take_byte) begin
      have_q        <= 1'b1;
      mask_q[col_q] <= 1'b1;
      col_q         <= col_step(col_q);
    end
  end

  for (genvar gi = 0; gi < EPW_PAGE_BYTES; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q[gi] <= EPW_ERASED;
      else if (take_byte && col_q == col_t'(gi)) slot_q[gi] <= byte_data;
    end
  end

  assign collecting = coll_q;
  assign have_byte  = have_q;
  assign page_base  = base_q;
  assign rd_byte    = slot_q[rd_col];
  assign rd_vld     = mask_q[rd_col];

  // R9
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q) && $stable(base_q));

  // R3
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && col_q == '1) |=> col_q == '0);

  // R7
  abort_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !busy) |=> !coll_q);
endmodule

// File: rtl/epw_commit_ctrl.sv
module epw_commit_ctrl
  import epw_pkg::*;
#(
  parameter int CYCLE_CLKS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_rise,
  input  logic [EPW_BIT_W-1:0] cs_bits,
  input  logic                 wr_allowed,
  input  logic                 abort,
  input  logic                 collecting,
  input  logic                 have_byte,
  output logic                 busy,
  output logic                 done,
  output logic                 in_copy,
  output col_t                 cur_col
);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);
  localparam logic [CNT_W-1:0] COPY_END = CNT_W'(EPW_PAGE_BYTES - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             commit_go;

  assign commit_go = cs_rise && !abort && (phase_q == PH_IDLE) && collecting &&
                     have_byte && on_boundary(cs_bits) && wr_allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (commit_go) begin
          phase_q <= PH_COPY;
          cnt_q   <= '0;
        end
      end else if (cnt_q == LAST_CNT) begin
        phase_q <= PH_IDLE;
        done_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == COPY_END) phase_q <= PH_HOLD;
      end
    end
  end

  assign busy    = phase_q != PH_IDLE;
  assign done    = done_q;
  assign in_copy = phase_q == PH_COPY;
  assign cur_col = cnt_q[EPW_COL_W-1:0];

  // independent run-length counter for the window check
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R8
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < (CNT_W+1)'(CYCLE_CLKS));

  // R8
  go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  // R8
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

// File: rtl/epw_array.sv
module epw_array
  import epw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  addr_t                 waddr,
  input  logic [EPW_DATA_W-1:0] wdata,
  input  logic                  re,
  input  addr_t                 raddr,
  output logic [EPW_DATA_W-1:0] rdata
);
  logic [EPW_DATA_W-1:0] cell_q [EPW_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < EPW_DEPTH; i++) cell_q[i] <= EPW_ERASED;
      rdata <= EPW_ERASED;
    end else begin
      if (we) cell_q[waddr] <= wdata;
      if (re) rdata <= cell_q[raddr];
    end
  end
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import epw_pkg::*;
#(
  parameter int CYCLE_CLKS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_start,
  input  logic [EPW_ADDR_W-1:0] wr_start_addr,
  input  logic                  wr_byte_valid,
  input  logic [EPW_DATA_W-1:0] wr_byte,
  input  logic                  cs_rise,
  input  logic [EPW_BIT_W-1:0]  cs_bits,
  input  logic                  wr_allowed,
  input  logic                  abort,
  input  logic                  rd_en,
  input  logic [EPW_ADDR_W-1:0] rd_addr,
  output logic [EPW_DATA_W-1:0] rd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  mem_we,
  output logic [EPW_ADDR_W-1:0] mem_addr,
  output logic [EPW_DATA_W-1:0] mem_wdata
);
  logic                  collecting, have_byte, in_copy, col_vld;
  page_t                 page_base;
  col_t                  cur_col;
  logic [EPW_DATA_W-1:0] col_byte;
  logic                  rd_go;

  epw_page_latch i_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .abort      (abort),
    .start      (wr_start),
    .start_addr (wr_start_addr),
    .byte_valid (wr_byte_valid),
    .byte_data  (wr_byte),
    .cs_rise    (cs_rise),
    .rd_col     (cur_col),
    .collecting (collecting),
    .have_byte  (have_byte),
    .page_base  (page_base),
    .rd_byte    (col_byte),
    .rd_vld     (col_vld)
  );

  epw_commit_ctrl #(.CYCLE_CLKS(CYCLE_CLKS)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .cs_bits    (cs_bits),
    .wr_allowed (wr_allowed),
    .abort      (abort),
    .collecting (collecting),
    .have_byte  (have_byte),
    .busy       (busy),
    .done       (done),
    .in_copy    (in_copy),
    .cur_col    (cur_col)
  );

  assign mem_we    = in_copy && col_vld;
  assign mem_addr  = join_addr(page_base, cur_col);
  assign mem_wdata = col_byte;
  assign rd_go     = rd_en && !busy;

  epw_array i_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R11
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5
  boundary_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_bits == '0 && wr_allowed));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_data));
endmodule

// File: tb/test_eeprom_page_commit.sv
module test_eeprom_page_commit;
  localparam int CYC = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_start = 0, wr_byte_valid = 0, cs_rise = 0, abort = 0, rd_en = 0;
  logic       wr_allowed = 1;
  logic [8:0] wr_start_addr = '0, rd_addr = '0;
  logic [7:0] wr_byte = '0;
  logic [2:0] cs_bits = '0;
  logic [7:0] rd_data, mem_wdata;
  logic [8:0] mem_addr;
  logic       busy, done, mem_we;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eeprom_page_commit #(.CYCLE_CLKS(CYC)) i_eeprom_page_commit (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_start_addr(wr_start_addr),
    .wr_byte_valid(wr_byte_valid), .wr_byte(wr_byte), .cs_rise(cs_rise),
    .cs_bits(cs_bits), .wr_allowed(wr_allowed), .abort(abort), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [512];
  logic [7:0] m_page [16];
  bit         m_got [16];
  int  m_base, m_col, m_cnt;
  bit  m_coll, m_have, m_busy, m_done;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_coll = 0; m_have = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_rd = 8'hFF;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (rd_en && !was_busy) m_rd = m_mem[rd_addr];
      if (was_busy) begin
        if (m_cnt < 16 && m_got[m_cnt]) m_mem[m_base*16 + m_cnt] = m_page[m_cnt];
        if (m_cnt == CYC-1) begin m_busy = 0; m_done = 1; end
        else m_cnt++;
      end else if (abort || cs_rise) begin
        if (cs_rise && !abort && m_coll && m_have && cs_bits == 0 && wr_allowed) begin
          m_busy = 1; m_cnt = 0;
        end
        m_coll = 0;
      end else if (wr_start) begin
        m_coll = 1; m_have = 0;
        m_base = wr_start_addr / 16; m_col = wr_start_addr % 16;
        foreach (m_got[i]) m_got[i] = 0;
      end else if (wr_byte_valid && m_coll) begin
        m_page[m_col] = wr_byte; m_got[m_col] = 1; m_have = 1;
        m_col = (m_col + 1) % 16;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit m_we;
      m_we = m_busy && m_cnt < 16 && m_got[m_cnt];
      chk("R8 busy", busy, m_busy);
      chk("R8 done", done, m_done);
      chk("R10 rd_data", rd_data, m_rd);
      chk("R11 mem_we", mem_we, m_we);
      if (m_we) begin
        chk("R11 mem_addr", mem_addr, m_base*16 + m_cnt);
        chk("R11 mem_wdata", mem_wdata, m_page[m_cnt]);
      end
    end
  end

  // ---------------- stimulus tasks (start and end at a falling edge) ----------------
  task automatic do_start(input logic [8:0] a);
    wr_start = 1; wr_start_addr = a; @(negedge clk); wr_start = 0;
  endtask
  task automatic do_byte(input logic [7:0] d);
    wr_byte_valid = 1; wr_byte = d; @(negedge clk); wr_byte_valid = 0;
  endtask
  task automatic do_cs(input logic [2:0] bits, input logic ok, input logic ab);
    cs_rise = 1; cs_bits = bits; wr_allowed = ok; abort = ab;
    @(negedge clk);
    cs_rise = 0; cs_bits = 0; wr_allowed = 1; abort = 0;
  endtask
  task automatic do_abort();
    abort = 1; @(negedge clk); abort = 0;
  endtask
  task automatic expect_mem(input logic [8:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1; rd_addr = a; @(negedge clk); rd_en = 0;
    chk(tag, rd_data, exp);
  endtask
  task automatic run_cycle(input int exp_we, input string tag);
    int cycles = 0, wes = 0;
    while (busy && cycles < 1000) begin
      if (mem_we) wes++;
      cycles++;
      @(negedge clk);
    end
    chk({tag, " busy length"}, cycles, CYC);
    chk({tag, " done pulse"}, done, 1);
    chk({tag, " write pulses"}, wes, exp_we);
    @(negedge clk);
    chk({tag, " done single"}, done, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    chk("R1 rd_data at reset", rd_data, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    expect_mem(9'h000, 8'hFF, "R1 erased low");
    expect_mem(9'h1FF, 8'hFF, "R1 erased high");

    // R2 / R4 / R11: two bytes from column 3 of page 0x12
    do_start(9'h123); do_byte(8'hA1); do_byte(8'hA2);
    do_cs(3'd0, 1'b1, 1'b0);
    chk("R8 busy after commit", busy, 1);
    run_cycle(2, "R8 R11");
    expect_mem(9'h123, 8'hA1, "R2 first column");
    expect_mem(9'h124, 8'hA2, "R2 next column");
    expect_mem(9'h122, 8'hFF, "R4 column before");
    expect_mem(9'h125, 8'hFF, "R4 column after");

    // R3: wrap from column 14
    do_start(9'h05E);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'h44);
    do_cs(3'd0, 1'b1, 1'b0);
    run_cycle(4, "R3");
    expect_mem(9'h05E, 8'h11, "R3 col14");
    expect_mem(9'h05F, 8'h22, "R3 col15");
    expect_mem(9'h050, 8'h33, "R3 wrapped col0");
    expect_mem(9'h051, 8'h44, "R3 wrapped col1");
    expect_mem(9'h060, 8'hFF, "R3 next page untouched");

    // R3: 18 bytes overwrite columns 0 and 1
    do_start(9'h080);
    for (int i = 0; i < 18; i++) do_byte(8'h40 + 8'(i));
    do_cs(3'd0, 1'b1, 1'b0);
    run_cycle(16, "R3 full page");
    expect_mem(9'h080, 8'h50, "R3 overwrite col0");
    expect_mem(9'h081, 8'h51, "R3 overwrite col1");
    expect_mem(9'h082, 8'h42, "R3 col2 kept");
    expect_mem(9'h08F, 8'h4F, "R3 col15");

    // R5: rise off a byte boundary
    do_start(9'h100); do_byte(8'h77); do_cs(3'd3, 1'b1, 1'b0);
    chk("R5 no busy on bit 3", busy, 0);
    expect_mem(9'h100, 8'hFF, "R5 bit-count cancel");
    // R5: no data byte
    do_start(9'h100); do_cs(3'd0, 1'b1, 1'b0);
    chk("R5 no busy without byte", busy, 0);
    // R6: permission refused
    do_start(9'h140); do_byte(8'h55); do_cs(3'd0, 1'b0, 1'b0);
    chk("R6 no busy when refused", busy, 0);
    expect_mem(9'h140, 8'hFF, "R6 refused write");
    // R7: abort mid-command
    do_start(9'h140); do_byte(8'h55); do_abort(); do_byte(8'h66);
    do_cs(3'd0, 1'b1, 1'b0);
    chk("R7 no busy after abort", busy, 0);
    expect_mem(9'h140, 8'hFF, "R7 aborted col0");
    expect_mem(9'h141, 8'hFF, "R7 aborted col1");

    // R9: requests during the programming cycle
    expect_mem(9'h123, 8'hA1, "R10 idle read");
    do_start(9'h1F0); do_byte(8'h9A); do_cs(3'd0, 1'b1, 1'b0);
    do_start(9'h000); do_byte(8'hEE); do_cs(3'd0, 1'b1, 1'b0); do_abort();
    rd_en = 1; rd_addr = 9'h1F0; @(negedge clk); rd_en = 0;
    chk("R9 rd_data held", rd_data, 8'hA1);
    chk("R9 still busy", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R9 no second cycle", busy, 0);
    expect_mem(9'h1F0, 8'h9A, "R9 cycle completed");
    expect_mem(9'h000, 8'hFF, "R9 ignored byte");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule